// File: doc/BRIEF.md
# Aperture Address Remapping Table

The block translates addresses inside one contiguous graphics aperture into physical addresses of 4 KB pages that may lie anywhere in main memory. A single-level table of page entries sits on chip. Each entry has a valid flag and a 20-bit physical page number. The table is indexed by the page offset of the request inside the aperture window. Addresses that miss the window leave the block unchanged.

Two requesters share one translation stage: a graphics port and a general bus port. A round-robin arbiter grants at most one of them per cycle. The grant is combinational, and the result is registered once. A requester keeps its request up until it sees its grant.

Software uses a small register port to set the window base, its enable and its size, and to write table entries. Walking a table held in memory, caching and coherency are outside this block.

Top module: `aperture_remap`

## Requirements
- R1: After reset, mem_valid_o, err_o and both grants are low, the window is disabled and every table entry is invalid.
- R2: A granted address that misses the window, or any address while the window is disabled, appears unchanged on mem_addr_o. mem_valid_o is high in the cycle after the grant.
- R3: A granted address inside the window produces {ppn, addr[11:0]} on mem_addr_o in the cycle after the grant. The index is (addr - base) >> 12, so neighbouring aperture pages can land on unrelated physical pages.
- R4: Size code c (0..6) gives a window of 4 MB << c. Codes above 6 act as 6 (256 MB). The low bits of the base below the window size are ignored, so the window is always aligned to its size.
- R5: A window hit on an invalid entry, or on an index at or beyond the table depth, pulses err_o for one cycle and keeps mem_valid_o low. mem_valid_o and err_o are never high together.
- R6: Requests from the bus port are translated exactly like graphics requests. mem_src_o gives the granted port: 0 for graphics, 1 for bus.
- R7: A lone request is granted in the same cycle. When both ports request together, the port that did not win the previous grant wins. The first conflict after reset goes to graphics.
- R8: Register encoding is as follows. With cfg_tbl_i=0 and cfg_addr_i[0]=0, cfg_wdata_i[31:22] sets the base and cfg_wdata_i[0] the enable. With cfg_tbl_i=0 and cfg_addr_i[0]=1, cfg_wdata_i[2:0] sets the size code. With cfg_tbl_i=1, the entry at cfg_addr_i is written with valid=cfg_wdata_i[31] and ppn=cfg_wdata_i[19:0]. Writes take effect for requests granted after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gfx_req_i | input | 1 | Graphics request |
| gfx_addr_i | input | 32 | Graphics address |
| gfx_gnt_o | output | 1 | Graphics grant (combinational) |
| bus_req_i | input | 1 | General bus request |
| bus_addr_i | input | 32 | General bus address |
| bus_gnt_o | output | 1 | General bus grant (combinational) |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_tbl_i | input | 1 | 1: table entry write, 0: window register write |
| cfg_addr_i | input | 10 | Entry index, or register select in bit 0 |
| cfg_wdata_i | input | 32 | Write data |
| mem_valid_o | output | 1 | Translated memory access valid |
| mem_addr_o | output | 32 | Physical address |
| mem_src_o | output | 1 | Port that owns the current result |
| err_o | output | 1 | Translation error response |

## Verification
Grants are combinational, so the bench checks them 1 ns after it drives the requests, which is still before the next rising edge. The translated address, the error pulse and the source bit come from one register stage. The bench samples them at the falling edge that follows the grant edge.

Register and table writes are driven at a falling edge and take effect at the next rising edge. Every request issued after that rising edge is predicted from the bench's own model of the new configuration. The round-robin winner is predicted from a model of the last winner that the bench updates on every grant.

// File: rtl/ar_pkg.sv
package ar_pkg;
  localparam int unsigned PAGE_W    = 12;
  localparam int unsigned PPN_W     = 20;
  localparam int unsigned MIN_SHIFT = 22;  // 4 MB smallest window
  localparam int unsigned MAX_CODE  = 6;   // 256 MB largest window

  typedef struct packed {
    logic             valid;
    logic [PPN_W-1:0] ppn;
  } pte_t;
endpackage

// File: rtl/ar_arbiter.sv
module ar_arbiter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  output logic [1:0] gnt_o
);
  logic last_q;  // 1: bus won last

  always_comb begin
    if (&req_i) gnt_o = last_q ? 2'b01 : 2'b10;
    else        gnt_o = req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= 1'b1;
    else if (|gnt_o) last_q <= gnt_o[1];
  end

  assert_gnt_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_gnt_needs_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == 2'b00);
  assert_rr_alternate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&req_i && gnt_o[0]) |=> (!(&req_i) || gnt_o[1]));
endmodule

// File: rtl/ar_window.sv
module ar_window
  import ar_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned VPN_W = ADDR_W - PAGE_W
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [2:0]        code_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [VPN_W-1:0]  idx_o
);
  logic [2:0]        code_c;
  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    code_c   = (code_i > 3'(MAX_CODE)) ? 3'(MAX_CODE) : code_i;
    low_mask = (ADDR_W'(1) << (MIN_SHIFT + 32'(code_c))) - ADDR_W'(1);
    hit_o    = en_i && ((addr_i & ~low_mask) == (base_i & ~low_mask));
    offset   = addr_i & low_mask;
    idx_o    = offset[ADDR_W-1:PAGE_W];
  end
endmodule

// File: rtl/ar_table.sv
module ar_table
  import ar_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  pte_t             wentry_i,
  input  logic [IDX_W-1:0] ridx_i,
  output pte_t             rentry_o
);
  pte_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wentry_i;
    end
  end

  assign rentry_o = mem_q[ridx_i];
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import ar_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned TBL_DEPTH = 1024,
  localparam int unsigned IDX_W    = $clog2(TBL_DEPTH),
  localparam int unsigned VPN_W    = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gfx_req_i,
  input  logic [ADDR_W-1:0] gfx_addr_i,
  output logic              gfx_gnt_o,
  input  logic              bus_req_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              bus_gnt_o,
  input  logic              cfg_we_i,
  input  logic              cfg_tbl_i,
  input  logic [IDX_W-1:0]  cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_src_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << MIN_SHIFT) - ADDR_W'(1));

  logic              en_q;
  logic [ADDR_W-1:0] base_q;
  logic [2:0]        code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      base_q <= '0;
      code_q <= '0;
    end else if (cfg_we_i && !cfg_tbl_i) begin
      if (!cfg_addr_i[0]) begin
        base_q <= cfg_wdata_i & BASE_MASK;
        en_q   <= cfg_wdata_i[0];
      end else begin
        code_q <= cfg_wdata_i[2:0];
      end
    end
  end

  logic [1:0] gnt;
  ar_arbiter u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i ({bus_req_i, gfx_req_i}),
    .gnt_o (gnt)
  );
  assign gfx_gnt_o = gnt[0];
  assign bus_gnt_o = gnt[1];

  logic              any_gnt;
  logic [ADDR_W-1:0] sel_addr;
  assign any_gnt  = |gnt;
  assign sel_addr = gnt[1] ? bus_addr_i : gfx_addr_i;

  logic             hit;
  logic [VPN_W-1:0] idx;
  ar_window #(.ADDR_W(ADDR_W)) u_win (
    .en_i  (en_q),
    .base_i(base_q),
    .code_i(code_q),
    .addr_i(sel_addr),
    .hit_o (hit),
    .idx_o (idx)
  );

  pte_t wentry, rentry;
  assign wentry.valid = cfg_wdata_i[ADDR_W-1];
  assign wentry.ppn   = cfg_wdata_i[PPN_W-1:0];

  ar_table #(.DEPTH(TBL_DEPTH)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && cfg_tbl_i),
    .widx_i  (cfg_addr_i),
    .wentry_i(wentry),
    .ridx_i  (idx[IDX_W-1:0]),
    .rentry_o(rentry)
  );

  logic in_tbl, good;
  assign in_tbl = idx < VPN_W'(TBL_DEPTH);
  assign good   = in_tbl && rentry.valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_valid_o <= 1'b0;
      err_o       <= 1'b0;
      mem_addr_o  <= '0;
      mem_src_o   <= 1'b0;
    end else begin
      mem_valid_o <= any_gnt && (!hit || good);
      err_o       <= any_gnt && hit && !good;
      if (any_gnt) begin
        mem_addr_o <= hit ? {rentry.ppn, sel_addr[PAGE_W-1:0]} : sel_addr;
        mem_src_o  <= gnt[1];
      end
    end
  end

  assert_one_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_valid_o && err_o));
  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_gnt |=> (mem_valid_o || err_o));
  assert_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_gnt && !hit) |=> (mem_valid_o && mem_addr_o == $past(sel_addr)));
  assert_page_offset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_addr_o[PAGE_W-1:0] == $past(sel_addr[PAGE_W-1:0]));
  assert_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_gnt |=> mem_src_o == $past(gnt[1]));
endmodule

// File: tb/aperture_remap_bench.sv
module aperture_remap_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gfx_req = 1'b0, bus_req = 1'b0;
  logic [31:0] gfx_addr = '0, bus_addr = '0;
  logic        gfx_gnt, bus_gnt;
  logic        cfg_we = 1'b0, cfg_tbl = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_valid, mem_src, err;
  logic [31:0] mem_addr;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  aperture_remap u_aperture_remap (
    .clk_i(clk), .rst_ni(rst_n),
    .gfx_req_i(gfx_req), .gfx_addr_i(gfx_addr), .gfx_gnt_o(gfx_gnt),
    .bus_req_i(bus_req), .bus_addr_i(bus_addr), .bus_gnt_o(bus_gnt),
    .cfg_we_i(cfg_we), .cfg_tbl_i(cfg_tbl), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .mem_valid_o(mem_valid), .mem_addr_o(mem_addr), .mem_src_o(mem_src), .err_o(err)
  );

  // bench model
  logic        m_en = 1'b0;
  logic [31:0] m_base = '0;
  logic [2:0]  m_code = '0;
  logic        m_v [1024];
  logic [19:0] m_p [1024];
  logic        m_last = 1'b1;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [32:0] predict(input logic [31:0] a);
    logic [31:0] size, lo;
    logic [19:0] ix;
    logic        e;
    size = 32'h0040_0000 << ((m_code > 3'd6) ? 3'd6 : m_code);
    lo   = size - 1;
    if (m_en && ((a & ~lo) == (m_base & ~lo))) begin
      ix = 20'((a & lo) >> 12);
      e  = (ix >= 20'd1024) || !m_v[ix[9:0]];
      return {e, e ? 32'h0 : {m_p[ix[9:0]], a[11:0]}};
    end
    return {1'b0, a};
  endfunction

  task automatic cfg_write(input logic tbl, input logic [9:0] ad, input logic [31:0] wd);
    cfg_we = 1'b1; cfg_tbl = tbl; cfg_addr = ad; cfg_wdata = wd;
    @(negedge clk);
    cfg_we = 1'b0;
    if (tbl) begin m_v[ad] = wd[31]; m_p[ad] = wd[19:0]; end
    else if (!ad[0]) begin m_base = wd & 32'hFFC0_0000; m_en = wd[0]; end
    else m_code = wd[2:0];
  endtask

  // drive at a falling edge, check grant now, result at the next falling edge
  task automatic issue(input logic gr, input logic [31:0] ga, input logic br, input logic [31:0] ba, input string tag);
    logic        win;
    logic [32:0] pr;
    gfx_req = gr; gfx_addr = ga; bus_req = br; bus_addr = ba;
    #1;
    win = (gr && br) ? !m_last : br;
    check(gfx_gnt == (gr && !win), {tag, " R7 gfx_gnt"}, 32'(gfx_gnt), 32'(gr && !win));
    check(bus_gnt == (br && win), {tag, " R7 bus_gnt"}, 32'(bus_gnt), 32'(br && win));
    pr = predict(win ? ba : ga);
    @(negedge clk);
    gfx_req = 1'b0; bus_req = 1'b0;
    if (gr || br) begin
      m_last = win;
      check(err == pr[32], {tag, " R5 err"}, 32'(err), 32'(pr[32]));
      check(mem_valid == !pr[32], {tag, " R2 valid"}, 32'(mem_valid), 32'(!pr[32]));
      if (!pr[32]) check(mem_addr == pr[31:0], {tag, " R3 addr"}, mem_addr, pr[31:0]);
      check(mem_src == win, {tag, " R6 src"}, 32'(mem_src), 32'(win));
    end else begin
      check(!mem_valid && !err, {tag, " R2 idle"}, {30'd0, mem_valid, err}, 32'd0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) begin m_v[i] = 1'b0; m_p[i] = '0; end
    repeat (3) @(negedge clk);
    check(!mem_valid && !err && !gfx_gnt && !bus_gnt, "R1 reset outputs",
          {28'd0, mem_valid, err, gfx_gnt, bus_gnt}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 first conflict after reset goes to graphics; R1 window disabled
    issue(1'b1, 32'h0000_0123, 1'b1, 32'h0000_4567, "r7_first");
    issue(1'b1, 32'h0000_1234, 1'b0, 32'h0, "r1_disabled_pass");
    // R1 entries start invalid: enable window at 0, look up entry 5
    cfg_write(1'b0, 10'd0, 32'h0000_0001);
    issue(1'b1, 32'h0000_5ABC, 1'b0, 32'h0, "r1_entry_invalid");
    // R4 base low bits ignored, R8 encodings
    cfg_write(1'b0, 10'd0, 32'h4012_3401);
    cfg_write(1'b0, 10'd1, 32'h0000_0000);
    cfg_write(1'b1, 10'd0, 32'h800A_BCDE);
    cfg_write(1'b1, 10'd1, 32'h8000_0011);
    cfg_write(1'b1, 10'd2, 32'h0001_2345);
    issue(1'b1, 32'h4000_0567, 1'b0, 32'h0, "r3_entry0");
    issue(1'b0, 32'h0, 1'b1, 32'h4000_1FFF, "r6_bus_entry1");
    issue(1'b1, 32'h4000_2004, 1'b0, 32'h0, "r5_invalid");
    issue(1'b1, 32'h4040_0000, 1'b0, 32'h0, "r2_above_window");
    issue(1'b0, 32'h0, 1'b1, 32'h3FFF_FFFF, "r2_below_window");
    // R4 code clamp: 7 acts as 256 MB, index beyond table gives R5 error
    cfg_write(1'b0, 10'd1, 32'h0000_0007);
    issue(1'b1, 32'h4FFF_F000, 1'b0, 32'h0, "r4_clamp_beyond");
    cfg_write(1'b0, 10'd1, 32'h0000_0001);
    issue(1'b1, 32'h4040_0000, 1'b0, 32'h0, "r4_8mb_idx1024");
    issue(1'b1, 32'h4000_0010, 1'b0, 32'h0, "r3_8mb_entry0");
    // R7 alternation under sustained conflict
    for (int k = 0; k < 6; k++) issue(1'b1, 32'h4000_0000 + 32'(k), 1'b1, 32'h4000_1000 + 32'(k), "r7_alternate");
    // random
    for (int blk = 0; blk < 20; blk++) begin
      cfg_write(1'b0, 10'd0, ($urandom & 32'hFFC0_0000) | 32'(($urandom % 8) != 0));
      cfg_write(1'b0, 10'd1, 32'($urandom % 8));
      for (int w = 0; w < 40; w++)
        cfg_write(1'b1, 10'($urandom), ($urandom & 32'h800F_FFFF));
      for (int n = 0; n < 150; n++) begin
        logic [31:0] ga, ba, sz;
        sz = 32'h0040_0000 << ((m_code > 3'd6) ? 3'd6 : m_code);
        ga = ($urandom % 4 != 0) ? ((m_base & ~(sz - 1)) | (((($urandom % 1100) << 12) | ($urandom & 32'hFFF)) & (sz - 1))) : $urandom;
        ba = ($urandom % 4 != 0) ? ((m_base & ~(sz - 1)) | (((($urandom % 1100) << 12) | ($urandom & 32'hFFF)) & (sz - 1))) : $urandom;
        issue(1'($urandom), ga, 1'($urandom), ba, "rand");
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule